// File: doc/BRIEF.md
# Receive Frame Tag Collector

This block builds a short tag word for every received frame. External address or protocol logic watches the receive nibble stream. After the start of a frame it drives a one-bit tag stream into the block on the receive clock. The stream has two wires: a data bit, and an enable that marks the cycles carrying a valid bit. The block shifts these bits into a 15-bit register, most significant bit first. If the external logic sends fewer than 15 bits, the tag still comes out right-aligned and the unused high bits are zero.

Shifting is allowed only once the byte-boundary strobe has marked the start of data in the current frame. It stops at the last cycle in which the frame-valid input is high. When frame-valid drops, the collected tag is copied into a holding register and a one-cycle valid pulse is raised. The shift register is then cleared for the next frame.

Two configuration inputs gate the result. Unless both are high, the reported tag is zero. The tag is also presented already placed in its field of a 32-bit receive status word.

Top module: `rx_frame_tag`

## Requirements
- R1: While reset is held, and after its release until the first frame ends, `tag_q` is zero, `tag_vld` is low and `stat_word` is zero.
- R2: Each accepted bit moves the tag register left by one place and enters at bit 0, so the first bit of a 15-bit stream ends in bit 14.
- R3: When fewer than 15 bits are accepted in a frame, the reported tag holds them in its low bits and every higher bit is zero.
- R4: When more than 15 bits are accepted, the bits that leave bit 14 are lost and the tag holds the last 15 bits received.
- R5: A bit is accepted only in a cycle where `tag_en` is high; cycles with `tag_en` low leave the tag unchanged whatever `tag_bit` is.
- R6: Bits offered in a frame before the first `byte_strb`, including the strobe cycle itself, are not accepted.
- R7: The first rising clock edge at which `rx_dv` is sampled low after being high ends the frame. At that edge `tag_q` takes the collected tag and `tag_vld` goes high for exactly one cycle.
- R8: The tag register is cleared at each frame end, so a frame that accepts no bits reports zero even after a frame with a full tag.
- R9: If `cfg_ext_sel` or `cfg_tag_on` is low at the frame-end edge, the reported tag is zero. `tag_vld` still pulses.
- R10: `stat_word` carries `tag_q` in bits 30 to 16, and its bits 31 and 15 to 0 are zero.
- R11: A bit offered in the cycle where `rx_dv` is already low (the frame-end cycle) is not part of that frame's tag.
- R12: `tag_q` and `stat_word` hold their value between frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_dv | input | 1 | High while a frame is being received |
| byte_strb | input | 1 | Byte-boundary strobe; its first pulse in a frame opens the tag window |
| tag_en | input | 1 | Marks a cycle carrying a valid tag bit |
| tag_bit | input | 1 | Serial tag data, most significant bit first |
| cfg_ext_sel | input | 1 | External-detection select enable |
| cfg_tag_on | input | 1 | Frame-tag enable |
| tag_q | output | 15 | Tag of the most recently ended frame |
| tag_vld | output | 1 | One-cycle pulse when `tag_q` is updated |
| stat_word | output | 32 | Receive status word with the tag in bits 30 to 16 |

## Verification
The assertions assume that `rx_dv` stays high for at least one cycle per frame. This means frame ends can never fall on two adjacent cycles. They also assume the configuration inputs only matter at the frame-end edge, so the gating check looks at them at that edge alone. The stimulus keeps to this. It changes inputs only on the falling clock edge, holds every frame open for several cycles, and drives noise on `tag_bit` and `tag_en` outside the window. That noise tests that the window and the enable are honoured, without breaking the assumptions above.

// File: rtl/rxtag_pkg.sv
package rxtag_pkg;
  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_HUNT = 2'd1,
    FS_OPEN = 2'd2
  } frame_state_e;
endpackage

// File: rtl/rxtag_frame_ctrl.sv
module rxtag_frame_ctrl
  import rxtag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_dv,
  input  logic byte_strb,
  input  logic tag_en,
  output logic shift_ok,
  output logic frame_end
);
  frame_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      FS_IDLE: if (rx_dv) state_d = byte_strb ? FS_OPEN : FS_HUNT;
      FS_HUNT: if (!rx_dv) state_d = FS_IDLE;
               else if (byte_strb) state_d = FS_OPEN;
      FS_OPEN: if (!rx_dv) state_d = FS_IDLE;
      default: state_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= FS_IDLE;
    else        state_q <= state_d;
  end

  assign shift_ok  = (state_q == FS_OPEN) && rx_dv && tag_en;
  assign frame_end = (state_q != FS_IDLE) && !rx_dv;

  // R6: the window may only open on a strobe seen while in a frame
  a_r6_open_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != FS_OPEN) ##1 (state_q == FS_OPEN) |-> $past(byte_strb) && $past(rx_dv));
endmodule

// File: rtl/rxtag_shifter.sv
module rxtag_shifter #(
  parameter int TAG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             din,
  input  logic             clr,
  output logic [TAG_W-1:0] sreg
);
  logic [TAG_W-1:0] sreg_d;
  logic             sreg_ce;

  assign sreg_ce = shift || clr;

  always_comb begin
    if (clr) sreg_d = '0;
    else     sreg_d = {sreg[TAG_W-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sreg <= '0;
    else if (sreg_ce) sreg <= sreg_d;
  end

  // R2: left shift, new bit at bit 0
  a_r2_left_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clr) |=> (sreg[0] == $past(din)) && (sreg[TAG_W-1:1] == $past(sreg[TAG_W-2:0])));
  // R5: no enable, no change
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift && !clr) |=> $stable(sreg));
  // R8: cleared at frame end
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sreg == '0));
endmodule

// File: rtl/rxtag_capture.sv
module rxtag_capture #(
  parameter int TAG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             pass,
  input  logic [TAG_W-1:0] tag_in,
  output logic [TAG_W-1:0] tag_q,
  output logic             tag_vld
);
  logic [TAG_W-1:0] tag_d;

  always_comb tag_d = pass ? tag_in : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tag_q <= '0;
    else if (take) tag_q <= tag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_vld <= 1'b0;
    else        tag_vld <= take;
  end

  // R7: valid is a single-cycle pulse
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tag_vld |=> !tag_vld);
  // R12: tag holds between updates
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_vld |-> $stable(tag_q));
endmodule

// File: rtl/rx_frame_tag.sv
module rx_frame_tag #(
  parameter int TAG_W  = 15,
  parameter int STAT_W = 32,
  parameter int TAG_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_dv,
  input  logic              byte_strb,
  input  logic              tag_en,
  input  logic              tag_bit,
  input  logic              cfg_ext_sel,
  input  logic              cfg_tag_on,
  output logic [TAG_W-1:0]  tag_q,
  output logic              tag_vld,
  output logic [STAT_W-1:0] stat_word
);
  localparam int TAG_MSB = TAG_LSB + TAG_W - 1;

  logic [1:0] rst_sync;
  logic       rst_int_n;
  logic       shift_ok, frame_end;
  logic [TAG_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  rxtag_frame_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .rx_dv     (rx_dv),
    .byte_strb (byte_strb),
    .tag_en    (tag_en),
    .shift_ok  (shift_ok),
    .frame_end (frame_end)
  );

  rxtag_shifter #(.TAG_W(TAG_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_int_n),
    .shift (shift_ok),
    .din   (tag_bit),
    .clr   (frame_end),
    .sreg  (sreg)
  );

  rxtag_capture #(.TAG_W(TAG_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .take    (frame_end),
    .pass    (cfg_ext_sel && cfg_tag_on),
    .tag_in  (sreg),
    .tag_q   (tag_q),
    .tag_vld (tag_vld)
  );

  always_comb begin
    stat_word = '0;
    stat_word[TAG_MSB:TAG_LSB] = tag_q;
  end

  // R9: gated tag reads zero
  a_r9_gate_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (frame_end && !(cfg_ext_sel && cfg_tag_on)) |=> (tag_q == '0));
  // R7: valid follows every frame end
  a_r7_vld_after_end: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_end |=> tag_vld);
  // R11: no shift accepted while the frame is already over
  a_r11_no_late_shift: assert property (@(posedge clk) disable iff (!rst_int_n)
    frame_end |-> !shift_ok);
endmodule

// File: tb/rx_frame_tag_test.sv
`timescale 1ns/1ps
module rx_frame_tag_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_dv = 1'b0, byte_strb = 1'b0, tag_en = 1'b0, tag_bit = 1'b0;
  logic cfg_ext_sel = 1'b0, cfg_tag_on = 1'b0;
  logic [14:0] tag_q;
  logic        tag_vld;
  logic [31:0] stat_word;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rx_frame_tag uut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .byte_strb(byte_strb),
    .tag_en(tag_en), .tag_bit(tag_bit), .cfg_ext_sel(cfg_ext_sel),
    .cfg_tag_on(cfg_tag_on), .tag_q(tag_q), .tag_vld(tag_vld),
    .stat_word(stat_word)
  );

  // {cfg[1:0], nbits[4:0], pattern[19:0], expected[14:0]}
  localparam int NV = 8;
  localparam logic [41:0] VEC [NV] = '{
    {2'b11, 5'd15, 20'h05A5A, 15'h5A5A},  // R2 full tag
    {2'b11, 5'd3,  20'h00005, 15'h0005},  // R3 short tag
    {2'b11, 5'd18, 20'h2ABCD, 15'h2BCD},  // R4 overflow
    {2'b11, 5'd0,  20'h00000, 15'h0000},  // R8 empty after full
    {2'b01, 5'd15, 20'h07FFF, 15'h0000},  // R9 ext sel low
    {2'b10, 5'd4,  20'h0000F, 15'h0000},  // R9 tag enable low
    {2'b11, 5'd1,  20'h00001, 15'h0001},  // R3 single bit
    {2'b11, 5'd15, 20'h04321, 15'h4321}   // R2 second pattern
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic dv, input logic st, input logic en, input logic b);
    @(negedge clk);
    rx_dv = dv; byte_strb = st; tag_en = en; tag_bit = b;
    @(posedge clk);
    #1;
  endtask

  // runs one frame; returns after the frame-end edge
  task automatic run_frame(input int nbits, input logic [19:0] pat);
    step(1'b1, 1'b0, 1'b1, 1'b1);   // R6 noise before strobe
    step(1'b1, 1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b1, 1'b1);   // R6 strobe cycle itself ignored
    for (int i = nbits - 1; i >= 0; i--) begin
      step(1'b1, 1'b0, 1'b1, pat[i]);
      step(1'b1, (i % 2) == 0, 1'b0, 1'b1);  // R5 disabled noise
    end
    step(1'b0, 1'b0, 1'b1, 1'b1);   // R11 bit in frame-end cycle
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [14:0] held;
    repeat (3) @(posedge clk);
    #1;
    check("R1 tag in reset", {17'd0, tag_q}, 32'd0);
    check("R1 vld in reset", {31'd0, tag_vld}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R1 stat after reset", stat_word, 32'd0);

    for (int v = 0; v < NV; v++) begin
      cfg_ext_sel = VEC[v][41];
      cfg_tag_on  = VEC[v][40];
      run_frame(int'(VEC[v][39:35]), VEC[v][34:15]);
      check("R7 vld at end", {31'd0, tag_vld}, 32'd1);
      check("R2 R3 R4 R8 R9 R11 tag", {17'd0, tag_q}, {17'd0, VEC[v][14:0]});
      check("R10 stat word", stat_word, {1'b0, VEC[v][14:0], 16'd0});
      held = tag_q;
      step(1'b0, 1'b0, 1'b1, 1'b1);
      check("R7 vld single", {31'd0, tag_vld}, 32'd0);
      step(1'b0, 1'b1, 1'b1, 1'b0);
      check("R12 hold", {17'd0, tag_q}, {17'd0, held});
    end

    // R6: frame with no strobe reports zero even with bits offered
    cfg_ext_sel = 1'b1; cfg_tag_on = 1'b1;
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R6 no strobe", {17'd0, tag_q}, 32'd0);
    check("R7 vld no strobe", {31'd0, tag_vld}, 32'd1);

    // R9: config changed mid-frame, only frame-end value matters
    cfg_tag_on = 1'b0;
    step(1'b1, 1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b1, 1'b1);
    cfg_tag_on = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R9 cfg at end", {17'd0, tag_q}, 32'h3);

    // R1: reset mid-frame clears output
    step(1'b1, 1'b1, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    check("R1 reset mid frame", stat_word, 32'd0);
    rx_dv = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    check("R1 vld after reset", {31'd0, tag_vld}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule